// File: doc/BRIEF.md
# Auto-Reload Memory-to-Memory DMA Channel

This block is a single DMA channel that copies a run of data units from one address range to another over a single-beat memory port. Software fills a small register bank with a starting source address, a starting destination address, one address-control field for each side and a control word. The control word sets the unit size, how each beat is triggered, whether a completion interrupt is raised, whether the channel reloads at the end, and how many units to move. Each beat reads one unit from the current source address and then writes it to the current destination address. After the write, both addresses advance or stay fixed and the remaining count drops by one.

The starting registers are kept apart from the working ones, which hold the current source, destination and count. This lets software prepare the next buffer while the present one is still moving. In reload mode the channel copies the prepared values into its working registers when the count reaches zero and stays on. The result is ping-pong buffering with no descriptor fetches. In single-shot mode the channel switches itself off at the end. Beats are paced in one of three ways: a software trigger that runs the whole buffer, a level-sensitive peripheral request, or a pulsed handshake with the peripheral.

Top module: `dma_reload_chan`

## Requirements
- R1: After reset every register reads zero, and `irq`, `periph_ack` and `mem_req` are low.
- R2: A beat is a read at the current source address, then a write of the captured read data to the current destination address. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_gnt`. The remaining count drops by one on the write grant.
- R3: Control bits [21:20] select the unit: 0 is a byte, 1 a halfword, 2 a word. Each address advances by 1, 2 or 4 bytes per beat, and `mem_size` carries that field on every access.
- R4: In each side's address-control register (offset 0x04 for the source, 0x0C for the destination), bit 0 set to 1 holds that address fixed and 0 makes it advance. Bit 1 drives `mem_periph` during that side's access.
- R5: Control bits [19:0] give the count in units. With control bit 22 set (single-shot), exactly that many beats run, and then the on bit (bit 1 at offset 0x20) clears and the status count (offset 0x14, bits [19:0]) reads 0.
- R6: When control bit 29 is set, `irq` pulses for exactly one cycle, the cycle after the write grant that brings the count to zero. It never pulses when bit 29 is clear.
- R7: With control bit 22 clear (reload), reaching zero copies the starting source, destination and count into the working registers, and the channel stays on. In software-trigger mode a new trigger is needed before the next buffer moves.
- R8: Writing 1 to bit 1 at offset 0x20 while the channel is off copies the starting registers into the working registers on that same clock edge, so offsets 0x14, 0x18 and 0x1C show them on the next cycle. Writes to the starting registers during a run do not change the run in progress.
- R9: Writing 1 to bit 2 at offset 0x20 lets any beat in flight finish. It then clears the on bit and the stop bit and leaves the count frozen. No memory request is made while the channel is off.
- R10: With control bit 23 clear, writing 1 to bit 0 at offset 0x20 runs every remaining beat up to zero. With bit 23 set, `periph_req` paces the beats. If bit 31 is clear, beats run as long as the request is high. If bit 31 is set, one beat runs per request assertion, and the request must drop before the next beat.
- R11: In hardware-trigger mode, `periph_ack` pulses for one cycle after the write grant of each beat.
- R12: Offsets 0x00, 0x04, 0x08, 0x0C and 0x10 read back what was written, including control bit 30. Offsets 0x18 and 0x1C read the current addresses. Offset 0x20 reads {stop pending, on, software trigger pending} in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| periph_req | input | 1 | Peripheral transfer request |
| periph_ack | output | 1 | One-cycle beat-complete pulse to the peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_size | output | 2 | Unit size of the access |
| mem_periph | output | 1 | Selects the peripheral bus for the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_gnt` on a read |
| mem_gnt | input | 1 | Access accepted this cycle |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Each result has a known arrival time. Working-register loads are visible the cycle after the on-bit write edge. With an immediate grant, a beat takes two cycles. `irq` and `periph_ack` arrive in the cycle after the final write grant. The checks never sample a register result in the cycle a write lands. Instead, they wait on the on bit or the trigger-pending bit through the read port, then read the count and addresses, so grant stalls from the bench's memory cannot shift a sample onto a changing value. Writes and pulses are logged at the clock edge where the handshake completes, and each logged entry is compared against an address and data pattern computed from the start address, the step and the beat index.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int CNT_W     = 20;
    localparam int REG_OFS_W = 6;

    localparam logic [REG_OFS_W-1:0] OFS_INIT_SRC = 6'h00;
    localparam logic [REG_OFS_W-1:0] OFS_SRC_CTL  = 6'h04;
    localparam logic [REG_OFS_W-1:0] OFS_INIT_DST = 6'h08;
    localparam logic [REG_OFS_W-1:0] OFS_DST_CTL  = 6'h0C;
    localparam logic [REG_OFS_W-1:0] OFS_CTRL     = 6'h10;
    localparam logic [REG_OFS_W-1:0] OFS_STATUS   = 6'h14;
    localparam logic [REG_OFS_W-1:0] OFS_CUR_SRC  = 6'h18;
    localparam logic [REG_OFS_W-1:0] OFS_CUR_DST  = 6'h1C;
    localparam logic [REG_OFS_W-1:0] OFS_RUNCMD   = 6'h20;

    typedef enum logic [1:0] {
        UNIT_BYTE = 2'd0,
        UNIT_HALF = 2'd1,
        UNIT_WORD = 2'd2,
        UNIT_RSVD = 2'd3
    } unit_e;

    // Address-control field, one per side of the copy.
    typedef struct packed {
        logic periph;   // bit 1: access goes to the peripheral bus
        logic hold;     // bit 0: address does not advance
    } side_ctl_t;

    // Control word layout.
    typedef struct packed {
        logic             handshake;  // 31
        logic             sync_sel;   // 30
        logic             irq_en;     // 29
        logic [4:0]       rsvd;       // 28:24
        logic             hw_trig;    // 23
        logic             no_reload;  // 22
        unit_e            unit;       // 21:20
        logic [CNT_W-1:0] count;      // 19:0
    } ctrl_t;

    // Run-command register bits.
    typedef struct packed {
        logic stop;
        logic on;
        logic trig;
    } run_cmd_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_READ,
        ENG_WRITE
    } eng_state_e;

    function automatic logic [2:0] unit_bytes(unit_e u);
        case (u)
            UNIT_BYTE: return 3'd1;
            UNIT_HALF: return 3'd2;
            default:   return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_cfg_bank.sv
module dma_cfg_bank
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_OFS_W-1:0] wr_ofs,
    input  logic [31:0]          wr_data,
    output logic [ADDR_W-1:0]    init_src,
    output logic [ADDR_W-1:0]    init_dst,
    output side_ctl_t            src_ctl,
    output side_ctl_t            dst_ctl,
    output ctrl_t                ctrl,
    output logic                 cmd_wr,
    output run_cmd_t             cmd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            init_src <= '0;
            init_dst <= '0;
            src_ctl  <= '0;
            dst_ctl  <= '0;
            ctrl     <= '0;
        end else if (wr_en) begin
            case (wr_ofs)
                OFS_INIT_SRC: init_src <= wr_data[ADDR_W-1:0];
                OFS_SRC_CTL:  src_ctl  <= side_ctl_t'(wr_data[1:0]);
                OFS_INIT_DST: init_dst <= wr_data[ADDR_W-1:0];
                OFS_DST_CTL:  dst_ctl  <= side_ctl_t'(wr_data[1:0]);
                OFS_CTRL:     ctrl     <= ctrl_t'(wr_data);
                default: ;
            endcase
        end
    end

    // Run-command writes are events, not stored here.
    assign cmd_wr = wr_en && (wr_ofs == OFS_RUNCMD);
    assign cmd    = run_cmd_t'(wr_data[2:0]);

endmodule

// File: rtl/dma_trig_gate.sv
module dma_trig_gate (
    input  logic clk,
    input  logic rst,
    input  logic hw_trig,
    input  logic handshake,
    input  logic sw_go,
    input  logic periph_req,
    input  logic beat_done,
    output logic beat_ok
);

    // In handshake mode one request assertion buys one beat.
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b1;
        else if (beat_done)
            armed <= 1'b0;
        else if (!periph_req)
            armed <= 1'b1;
    end

    always_comb begin
        if (!hw_trig)
            beat_ok = sw_go;
        else if (handshake)
            beat_ok = periph_req && armed;
        else
            beat_ok = periph_req;
    end

endmodule

// File: rtl/dma_beat_engine.sv
module dma_beat_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] init_src,
    input  logic [ADDR_W-1:0] init_dst,
    input  side_ctl_t         src_ctl,
    input  side_ctl_t         dst_ctl,
    input  ctrl_t             ctrl,
    input  logic              cmd_wr,
    input  run_cmd_t          cmd,
    input  logic              beat_ok,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_periph,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    output logic              chan_on,
    output logic              stop_pend,
    output logic              sw_go,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              beat_done,
    output logic              irq,
    output logic              periph_ack
);

    eng_state_e        state;
    logic [DATA_W-1:0] hold_data;
    logic [ADDR_W-1:0] src_step;
    logic [ADDR_W-1:0] dst_step;
    logic              last_beat;
    logic              turn_on;

    assign src_step  = src_ctl.hold ? '0 : {{(ADDR_W-3){1'b0}}, unit_bytes(ctrl.unit)};
    assign dst_step  = dst_ctl.hold ? '0 : {{(ADDR_W-3){1'b0}}, unit_bytes(ctrl.unit)};
    assign last_beat = (cur_cnt == CNT_W'(1));
    assign turn_on   = cmd_wr && cmd.on && !chan_on;
    assign beat_done = (state == ENG_WRITE) && mem_gnt;

    always_comb begin
        mem_req    = (state != ENG_IDLE);
        mem_we     = (state == ENG_WRITE);
        mem_addr   = (state == ENG_WRITE) ? cur_dst : cur_src;
        mem_periph = (state == ENG_WRITE) ? dst_ctl.periph : src_ctl.periph;
        mem_size   = ctrl.unit;
        mem_wdata  = hold_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ENG_IDLE;
            hold_data  <= '0;
            chan_on    <= 1'b0;
            stop_pend  <= 1'b0;
            sw_go      <= 1'b0;
            cur_src    <= '0;
            cur_dst    <= '0;
            cur_cnt    <= '0;
            irq        <= 1'b0;
            periph_ack <= 1'b0;
        end else begin
            irq        <= 1'b0;
            periph_ack <= 1'b0;

            if (turn_on) begin
                chan_on   <= 1'b1;
                stop_pend <= 1'b0;
                cur_src   <= init_src;
                cur_dst   <= init_dst;
                cur_cnt   <= ctrl.count;
            end
            if (cmd_wr && cmd.stop && chan_on)
                stop_pend <= 1'b1;
            if (cmd_wr && cmd.trig && (chan_on || turn_on))
                sw_go <= 1'b1;

            case (state)
                ENG_IDLE: begin
                    if (chan_on && stop_pend) begin
                        chan_on   <= 1'b0;
                        stop_pend <= 1'b0;
                        sw_go     <= 1'b0;
                    end else if (chan_on && (cur_cnt != '0) && beat_ok) begin
                        state <= ENG_READ;
                    end
                end
                ENG_READ: begin
                    if (mem_gnt) begin
                        hold_data <= mem_rdata;
                        state     <= ENG_WRITE;
                    end
                end
                ENG_WRITE: begin
                    if (mem_gnt) begin
                        state      <= ENG_IDLE;
                        periph_ack <= ctrl.hw_trig;
                        cur_src    <= cur_src + src_step;
                        cur_dst    <= cur_dst + dst_step;
                        cur_cnt    <= cur_cnt - CNT_W'(1);
                        if (last_beat) begin
                            irq   <= ctrl.irq_en;
                            sw_go <= 1'b0;
                            if (ctrl.no_reload) begin
                                chan_on   <= 1'b0;
                                stop_pend <= 1'b0;
                            end else begin
                                cur_src <= init_src;
                                cur_dst <= init_dst;
                                cur_cnt <= ctrl.count;
                            end
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_OFS_W-1:0] cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 periph_req,
    output logic                 periph_ack,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [1:0]           mem_size,
    output logic                 mem_periph,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_gnt,
    output logic                 irq
);

    logic [ADDR_W-1:0] init_src;
    logic [ADDR_W-1:0] init_dst;
    side_ctl_t         src_ctl;
    side_ctl_t         dst_ctl;
    ctrl_t             ctrl;
    logic              cmd_wr;
    run_cmd_t          cmd;
    logic              beat_ok;
    logic              beat_done;
    logic              chan_on;
    logic              stop_pend;
    logic              sw_go;
    logic [ADDR_W-1:0] cur_src;
    logic [ADDR_W-1:0] cur_dst;
    logic [CNT_W-1:0]  cur_cnt;

    dma_cfg_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_ofs   (cfg_addr),
        .wr_data  (cfg_wdata),
        .init_src (init_src),
        .init_dst (init_dst),
        .src_ctl  (src_ctl),
        .dst_ctl  (dst_ctl),
        .ctrl     (ctrl),
        .cmd_wr   (cmd_wr),
        .cmd      (cmd)
    );

    dma_trig_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .hw_trig    (ctrl.hw_trig),
        .handshake  (ctrl.handshake),
        .sw_go      (sw_go),
        .periph_req (periph_req),
        .beat_done  (beat_done),
        .beat_ok    (beat_ok)
    );

    dma_beat_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .init_src   (init_src),
        .init_dst   (init_dst),
        .src_ctl    (src_ctl),
        .dst_ctl    (dst_ctl),
        .ctrl       (ctrl),
        .cmd_wr     (cmd_wr),
        .cmd        (cmd),
        .beat_ok    (beat_ok),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_size   (mem_size),
        .mem_periph (mem_periph),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_gnt    (mem_gnt),
        .chan_on    (chan_on),
        .stop_pend  (stop_pend),
        .sw_go      (sw_go),
        .cur_src    (cur_src),
        .cur_dst    (cur_dst),
        .cur_cnt    (cur_cnt),
        .beat_done  (beat_done),
        .irq        (irq),
        .periph_ack (periph_ack)
    );

    always_comb begin
        case (cfg_addr)
            OFS_INIT_SRC: cfg_rdata = 32'(init_src);
            OFS_SRC_CTL:  cfg_rdata = {30'b0, src_ctl};
            OFS_INIT_DST: cfg_rdata = 32'(init_dst);
            OFS_DST_CTL:  cfg_rdata = {30'b0, dst_ctl};
            OFS_CTRL:     cfg_rdata = ctrl;
            OFS_STATUS:   cfg_rdata = {{(32-CNT_W){1'b0}}, cur_cnt};
            OFS_CUR_SRC:  cfg_rdata = 32'(cur_src);
            OFS_CUR_DST:  cfg_rdata = 32'(cur_dst);
            OFS_RUNCMD:   cfg_rdata = {29'b0, stop_pend, chan_on, sw_go};
            default:      cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq,
    input logic              periph_ack,
    input logic              chan_on,
    input logic [CNT_W-1:0]  cur_cnt
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R2

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R6

    AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mem_req && mem_we && mem_gnt)); // R6

    AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> chan_on); // R9

    AST_COUNT_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !chan_on |=> ($stable(cur_cnt) || chan_on)); // R9

    AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        periph_ack |-> $past(mem_req && mem_we && mem_gnt)); // R11

endmodule

bind dma_reload_chan dma_chan_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .irq        (irq),
    .periph_ack (periph_ack),
    .chan_on    (chan_on),
    .cur_cnt    (cur_cnt)
);

// File: tb/tb_dma_reload_chan.sv
`timescale 1ns/1ps
module tb_dma_reload_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic        mem_req, mem_we, mem_periph;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_gnt;
    logic        irq;
    logic        stall = 1'b0;
    logic        gnt_allow = 1'b1;
    logic        log_clr = 1'b0;

    int nvec = 0;
    int nfail = 0;
    int wn = 0;
    int irq_n = 0;
    int ack_n = 0;
    logic [31:0] wa [0:63];
    logic [31:0] wd [0:63];
    logic [1:0]  ws [0:63];
    logic        wp [0:63];

    always #2 clk = ~clk;

    function automatic logic [31:0] pat(logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    assign mem_gnt   = mem_req && gnt_allow;
    assign mem_rdata = pat(mem_addr);

    dma_reload_chan dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_req(periph_req),
        .periph_ack(periph_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_periph(mem_periph),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .irq(irq)
    );

    always @(negedge clk) gnt_allow <= stall ? ~gnt_allow : 1'b1;

    always @(posedge clk) begin
        if (log_clr) begin
            wn <= 0; irq_n <= 0; ack_n <= 0;
        end else begin
            if (mem_req && mem_gnt && mem_we) begin
                if (wn < 64) begin
                    wa[wn] <= mem_addr; wd[wn] <= mem_wdata;
                    ws[wn] <= mem_size; wp[wn] <= mem_periph;
                end
                wn <= wn + 1;
            end
            if (irq) irq_n <= irq_n + 1;
            if (periph_ack) ack_n <= ack_n + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic wait_cmd_bit(input int b, input logic v);
        logic [31:0] d;
        for (int i = 0; i < 600; i++) begin
            reg_rd(6'h20, d);
            if (d[b] == v) return;
        end
        chk(1'b0, "R10 wait timeout", d, {31'b0, v});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : main
        logic [31:0] d, c1, c2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        reg_rd(6'h14, d); chk(d == 0, "R1 status", d, 0);
        reg_rd(6'h20, d); chk(d == 0, "R1 runcmd", d, 0);
        reg_rd(6'h10, d); chk(d == 0, "R1 ctrl", d, 0);
        chk(!irq && !mem_req && !periph_ack, "R1 outputs", {irq, mem_req, periph_ack}, 0);

        // R12: readback including sync bit 30
        reg_wr(6'h10, 32'h4012_3456); reg_rd(6'h10, d); chk(d == 32'h4012_3456, "R12 ctrl", d, 32'h4012_3456);
        reg_wr(6'h00, 32'h0000_ABC0); reg_rd(6'h00, d); chk(d == 32'h0000_ABC0, "R12 init src", d, 32'h0000_ABC0);
        reg_wr(6'h04, 32'hFFFF_FFFE); reg_rd(6'h04, d); chk(d == 32'h2, "R12 src ctl", d, 32'h2);

        // Sweep: unit x src hold x dst hold x irq enable, single-shot, sw trigger
        for (int cfg = 0; cfg < 24; cfg++) begin
            int u, hs, hd, ie, step, cnt;
            logic [31:0] src, dst, ea, ed;
            u = cfg % 3; hs = (cfg / 3) % 2; hd = (cfg / 6) % 2; ie = (cfg / 12) % 2;
            step = 1 << u; cnt = 3 + (cfg % 2);
            src = 32'h1000 + cfg * 64; dst = 32'h8000 + cfg * 64;
            stall = cfg[0];
            reg_wr(6'h00, src); reg_wr(6'h08, dst);
            reg_wr(6'h04, {30'b0, 1'b0, hs[0]});
            reg_wr(6'h0C, {30'b0, 1'b1, hd[0]});
            reg_wr(6'h10, (ie << 29) | (1 << 22) | (u << 20) | cnt);
            clear_log();
            reg_wr(6'h20, 32'h3);
            wait_cmd_bit(1, 1'b0);
            idle(2);
            chk(wn == cnt, "R5 beat count", wn, cnt);
            for (int k = 0; k < cnt; k++) begin
                ea = dst + (hd ? 0 : k * step);
                ed = pat(src + (hs ? 0 : k * step));
                chk(wa[k] == ea, hd ? "R4 dst hold addr" : "R3 dst step addr", wa[k], ea);
                chk(wd[k] == ed, hs ? "R4 src hold data" : "R2 copied data", wd[k], ed);
                chk(ws[k] == 2'(u), "R3 mem_size", {30'b0, ws[k]}, u);
                chk(wp[k] == 1'b1, "R4 periph bus", {31'b0, wp[k]}, 1);
            end
            chk(irq_n == ie, "R6 irq pulses", irq_n, ie);
            chk(ack_n == 0, "R11 no ack in sw mode", ack_n, 0);
            reg_rd(6'h14, d); chk(d == 0, "R5 final count", d, 0);
        end
        stall = 1'b0;

        // R8 load and R9 stop under demand-mode hardware pacing (R10)
        reg_wr(6'h00, 32'h40); reg_wr(6'h08, 32'h80);
        reg_wr(6'h04, 0); reg_wr(6'h0C, 0);
        reg_wr(6'h10, (1 << 23) | (1 << 22) | (2 << 20) | 20);
        clear_log();
        reg_wr(6'h20, 32'h2);
        reg_rd(6'h14, d); chk(d == 20, "R8 count loaded", d, 20);
        reg_rd(6'h18, d); chk(d == 32'h40, "R8 cur src loaded", d, 32'h40);
        reg_rd(6'h1C, d); chk(d == 32'h80, "R8 cur dst loaded", d, 32'h80);
        periph_req = 1'b1;
        idle(7);
        reg_wr(6'h20, 32'h4);
        wait_cmd_bit(1, 1'b0);
        reg_rd(6'h14, c1);
        idle(10);
        reg_rd(6'h14, c2);
        chk(c1 == c2, "R9 count frozen", c2, c1);
        chk(c1 == 32'(20 - wn), "R9 count matches beats", c1, 20 - wn);
        chk(wn > 1, "R10 demand beats", wn, 2);
        chk(ack_n == wn, "R11 ack per beat", ack_n, wn);
        chk(!mem_req, "R9 no request when off", {31'b0, mem_req}, 0);
        reg_rd(6'h20, d); chk(d == 0, "R9 stop cleared", d, 0);
        periph_req = 1'b0;
        idle(3);

        // R10 handshake: one beat per assertion
        reg_wr(6'h10, (1 << 31) | (1 << 23) | (1 << 22) | (2 << 20) | 4);
        clear_log();
        reg_wr(6'h20, 32'h2);
        periph_req = 1'b1; idle(20);
        chk(wn == 1, "R10 handshake first", wn, 1);
        periph_req = 1'b0; idle(3);
        periph_req = 1'b1; idle(20);
        chk(wn == 2, "R10 handshake second", wn, 2);
        chk(ack_n == 2, "R11 handshake acks", ack_n, 2);
        periph_req = 1'b0;
        reg_wr(6'h20, 32'h4);
        wait_cmd_bit(1, 1'b0);

        // R7 auto-reload with next buffer written mid-run (R8)
        stall = 1'b1;
        reg_wr(6'h00, 32'h100); reg_wr(6'h08, 32'h200);
        reg_wr(6'h10, (1 << 29) | (2 << 20) | 4);
        clear_log();
        reg_wr(6'h20, 32'h3);
        reg_wr(6'h00, 32'h300); reg_wr(6'h08, 32'h400);
        reg_wr(6'h10, (1 << 29) | (2 << 20) | 3);
        wait_cmd_bit(0, 1'b0);
        idle(2);
        chk(wn == 4, "R8 first run untouched", wn, 4);
        for (int k = 0; k < 4; k++) begin
            chk(wa[k] == 32'h200 + 4 * k, "R8 first run addr", wa[k], 32'h200 + 4 * k);
            chk(wd[k] == pat(32'h100 + 4 * k), "R8 first run data", wd[k], pat(32'h100 + 4 * k));
        end
        reg_rd(6'h20, d); chk(d[1] == 1'b1, "R7 stays on", d, 32'h2);
        reg_rd(6'h14, d); chk(d == 3, "R7 reloaded count", d, 3);
        reg_rd(6'h18, d); chk(d == 32'h300, "R7 reloaded src", d, 32'h300);
        chk(irq_n == 1, "R6 irq at reload", irq_n, 1);
        reg_wr(6'h20, 32'h1);
        wait_cmd_bit(0, 1'b0);
        idle(2);
        chk(wn == 7, "R7 second buffer beats", wn, 7);
        for (int k = 0; k < 3; k++) begin
            chk(wa[4 + k] == 32'h400 + 4 * k, "R7 second addr", wa[4 + k], 32'h400 + 4 * k);
            chk(wd[4 + k] == pat(32'h300 + 4 * k), "R7 second data", wd[4 + k], pat(32'h300 + 4 * k));
        end
        chk(irq_n == 2, "R6 second irq", irq_n, 2);
        reg_rd(6'h14, d); chk(d == 3, "R7 count reloaded again", d, 3);
        reg_wr(6'h20, 32'h4);
        wait_cmd_bit(1, 1'b0);
        stall = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule